// File: doc/BRIEF.md
# Device-Side Coherent Line Agent

This block sits inside an accelerator and keeps a small, line-indexed cache of host memory coherent. Each line is 64 bytes and carries one of four MESI states. Local logic hands the block load, store, evict and push intents. The block serves hits on its own. When an intent needs the host, it raises one of four request classes on a device-to-host request port. The host's global-observation (GO) message on the host-to-device response port alone decides the state the line ends in. For reads, the line contents arrive separately on the host-to-device data port.

The host can revoke a line at any time with an invalidating snoop on the host-to-device request port. The block answers on a device-to-host response port. When it held the line modified, it returns the dirty contents on the device-to-host data port in the same cycle as that answer. It talks only to the host, never to peer devices. A single tracker holds the one outstanding host request. Local intents that target the tracked line, or that would need a second host request, are refused until the tracker retires.

Top module: `dev_coh_agent`

## Requirements
- R1: After reset every line is Invalid (state code 0; S=1, E=2, M=3), no output valid is high, and an idle block asserts loc_ready.
- R2: A load (op 0) to a line in S, E or M raises loc_done one cycle after acceptance, with the line's contents on loc_rdata and no host request.
- R3: A load to an Invalid line issues class Read (code 0) one cycle after acceptance. It completes only after both the GO and the host data for that line have arrived, in either order or together. loc_done then carries the host data, and the line takes the GO state.
- R4: A store (op 1) to a line in E or M completes locally with no host request, and leaves the line in M holding the store data.
- R5: A store to a line in S or I, or a push to a line in S, issues class Read0 (code 1). A GO granting E or M completes it, and the line becomes M holding the store data.
- R6: A push (op 3) to an Invalid line issues class Read0-Write (code 2), with the push data on the D2H data port in the same cycle. The line keeps the GO state (I). A push to a line in E or M acts as a local store.
- R7: An evict (op 2) of a line in M issues class Write (code 3), with the line contents on the D2H data port in the same cycle, and the GO (I) invalidates the line. An evict of a line in S, E or I completes locally and leaves the line Invalid.
- R8: An invalidating snoop is answered one cycle later with kind 0 (miss) for I, 1 (clean) for S or E, or 2 (dirty) for M. A dirty answer carries the line contents on the D2H data port in the same cycle. The line is Invalid afterwards.
- R9: When a GO and a snoop for the same line arrive in the same cycle, the GO is applied first and the snoop answer reflects the granted state.
- R10: While a host request is outstanding, local intents to that line and intents needing the host are refused. Two request pulses are never adjacent.
- R11: In any cycle with a snoop valid, loc_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_valid | input | 1 | Local intent present |
| loc_op | input | 2 | Intent: 0 load, 1 store, 2 evict, 3 push |
| loc_idx | input | IDX_W | Target line |
| loc_wdata | input | DATA_W | Store or push data |
| loc_ready | output | 1 | Intent accepted this cycle when valid |
| loc_done | output | 1 | Intent completed |
| loc_done_idx | output | IDX_W | Line of the completed intent |
| loc_rdata | output | DATA_W | Load data on completion |
| d2h_req_valid | output | 1 | Request to host |
| d2h_req_cls | output | 2 | Request class code |
| d2h_req_idx | output | IDX_W | Request line |
| d2h_rsp_valid | output | 1 | Snoop answer |
| d2h_rsp_kind | output | 2 | Snoop answer kind |
| d2h_rsp_idx | output | IDX_W | Snoop answer line |
| d2h_dat_valid | output | 1 | Line data to host |
| d2h_dat_idx | output | IDX_W | Line of outgoing data |
| d2h_dat | output | DATA_W | Outgoing line data |
| h2d_rsp_valid | input | 1 | GO message |
| h2d_rsp_idx | input | IDX_W | GO line |
| h2d_rsp_state | input | 2 | Granted MESI state |
| h2d_dat_valid | input | 1 | Host line data |
| h2d_dat_idx | input | IDX_W | Host data line |
| h2d_dat | input | DATA_W | Host line data |
| h2d_snp_valid | input | 1 | Invalidating snoop |
| h2d_snp_idx | input | IDX_W | Snoop line |

## Verification
The assertions watch, on every cycle, the properties that need no memory of earlier transactions. Every snoop is answered one cycle later and leaves its line Invalid. Dirty answers and Write or Read0-Write requests always carry data for the same line. Request pulses are never adjacent, and a local load hit never reaches the host. The class chosen for each state and intent, the GO-decided final state, completion in either GO/data order, and the GO-before-snoop ordering depend on history. Only the bench's directed and seeded random scenarios can show them, by checking against a reference state model.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
    typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_e;
    typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_EVICT = 2'd2, OP_PUSH = 2'd3} lop_e;
    typedef enum logic [1:0] {RQ_READ = 2'd0, RQ_READ0 = 2'd1, RQ_READ0_WR = 2'd2, RQ_WRITE = 2'd3} rqcls_e;
    typedef enum logic [1:0] {SR_MISS = 2'd0, SR_CLEAN = 2'd1, SR_DIRTY = 2'd2} snprsp_e;
    typedef enum logic [1:0] {ACT_LOAD_HIT = 2'd0, ACT_STORE_HIT = 2'd1, ACT_DROP = 2'd2, ACT_HOST = 2'd3} act_e;
endpackage

// File: rtl/dcc_req_sel.sv
module dcc_req_sel
    import dcc_pkg::*;
(
    input  mesi_e  st_i,
    input  lop_e   op_i,
    output act_e   act_o,
    output rqcls_e cls_o
);
    always_comb begin
        act_o = ACT_HOST;
        cls_o = RQ_READ;
        case (op_i)
            OP_LOAD: begin
                if (st_i != ST_I) act_o = ACT_LOAD_HIT;
            end
            OP_STORE: begin
                if (st_i == ST_E || st_i == ST_M) act_o = ACT_STORE_HIT;
                else cls_o = RQ_READ0;
            end
            OP_EVICT: begin
                if (st_i == ST_M) cls_o = RQ_WRITE;
                else act_o = ACT_DROP;
            end
            default: begin
                if (st_i == ST_I) cls_o = RQ_READ0_WR;
                else if (st_i == ST_S) cls_o = RQ_READ0;
                else act_o = ACT_STORE_HIT;
            end
        endcase
    end
endmodule

// File: rtl/dcc_snoop_unit.sv
module dcc_snoop_unit
    import dcc_pkg::*;
(
    input  mesi_e   st_i,
    output snprsp_e kind_o
);
    always_comb begin
        case (st_i)
            ST_M:       kind_o = SR_DIRTY;
            ST_S, ST_E: kind_o = SR_CLEAN;
            default:    kind_o = SR_MISS;
        endcase
    end
endmodule

// File: rtl/dcc_line_store.sv
module dcc_line_store #(
    parameter int NUM_LINES = 4,
    parameter int DATA_W    = 512,
    parameter int IDX_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wa_en,
    input  logic [IDX_W-1:0]  wa_idx,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] rb_data
);
    logic [NUM_LINES-1:0][DATA_W-1:0] rows;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [DATA_W-1:0] row_d, row_q;
        always_comb begin
            row_d = row_q;
            if (wb_en && wb_idx == IDX_W'(g)) row_d = wb_data;
            else if (wa_en && wa_idx == IDX_W'(g)) row_d = wa_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) row_q <= '0;
            else        row_q <= row_d;
        end
        assign rows[g] = row_q;
    end

    assign ra_data = rows[ra_idx];
    assign rb_data = rows[rb_idx];
endmodule

// File: rtl/dev_coh_agent.sv
module dev_coh_agent
    import dcc_pkg::*;
#(
    parameter int NUM_LINES  = 4,
    parameter int LINE_BYTES = 64,
    localparam int DATA_W = LINE_BYTES * 8,
    localparam int IDX_W  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_valid,
    input  logic [1:0]        loc_op,
    input  logic [IDX_W-1:0]  loc_idx,
    input  logic [DATA_W-1:0] loc_wdata,
    output logic              loc_ready,
    output logic              loc_done,
    output logic [IDX_W-1:0]  loc_done_idx,
    output logic [DATA_W-1:0] loc_rdata,
    output logic              d2h_req_valid,
    output logic [1:0]        d2h_req_cls,
    output logic [IDX_W-1:0]  d2h_req_idx,
    output logic              d2h_rsp_valid,
    output logic [1:0]        d2h_rsp_kind,
    output logic [IDX_W-1:0]  d2h_rsp_idx,
    output logic              d2h_dat_valid,
    output logic [IDX_W-1:0]  d2h_dat_idx,
    output logic [DATA_W-1:0] d2h_dat,
    input  logic              h2d_rsp_valid,
    input  logic [IDX_W-1:0]  h2d_rsp_idx,
    input  logic [1:0]        h2d_rsp_state,
    input  logic              h2d_dat_valid,
    input  logic [IDX_W-1:0]  h2d_dat_idx,
    input  logic [DATA_W-1:0] h2d_dat,
    input  logic              h2d_snp_valid,
    input  logic [IDX_W-1:0]  h2d_snp_idx
);
    typedef struct packed {
        mesi_e [NUM_LINES-1:0] st;
        logic                  busy;
        logic [IDX_W-1:0]      t_idx;
        rqcls_e                t_cls;
        lop_e                  t_op;
        logic                  t_go;
        logic                  t_dat;
        logic                  req_v;
        rqcls_e                req_cls;
        logic [IDX_W-1:0]      req_idx;
        logic                  rsp_v;
        snprsp_e               rsp_kind;
        logic [IDX_W-1:0]      rsp_idx;
        logic                  dat_v;
        logic [IDX_W-1:0]      dat_idx;
        logic [DATA_W-1:0]     dat;
        logic                  done_v;
        logic [IDX_W-1:0]      done_idx;
        logic [DATA_W-1:0]     rdata;
    } agent_t;

    agent_t s_d, s_q;

    mesi_e             loc_st, granted, go_final, snp_st;
    act_e              loc_act;
    rqcls_e            loc_cls;
    snprsp_e           snp_kind;
    logic              go_hit, dat_hit, complete, accept;
    logic              wa_en, wb_en;
    logic [IDX_W-1:0]  ra_idx;
    logic [DATA_W-1:0] ra_data, rb_data;

    assign loc_st = s_q.st[loc_idx];

    dcc_req_sel u_sel (
        .st_i  (loc_st),
        .op_i  (lop_e'(loc_op)),
        .act_o (loc_act),
        .cls_o (loc_cls)
    );

    // host-side events for the single tracker
    always_comb begin
        go_hit   = s_q.busy && h2d_rsp_valid && (h2d_rsp_idx == s_q.t_idx) && !s_q.t_go;
        dat_hit  = s_q.busy && (s_q.t_cls == RQ_READ) && h2d_dat_valid
                   && (h2d_dat_idx == s_q.t_idx) && !s_q.t_dat;
        complete = s_q.busy && (s_q.t_go || go_hit)
                   && (s_q.t_dat || dat_hit || s_q.t_cls != RQ_READ);
        granted  = mesi_e'(h2d_rsp_state);
        go_final = granted;
        if ((s_q.t_op == OP_STORE || s_q.t_op == OP_PUSH) && s_q.t_cls == RQ_READ0
            && (granted == ST_E || granted == ST_M))
            go_final = ST_M;
        // a GO in the same cycle is ordered ahead of the snoop
        snp_st = (go_hit && h2d_snp_idx == s_q.t_idx) ? go_final : s_q.st[h2d_snp_idx];
        loc_ready = !h2d_snp_valid && !complete
                    && !(s_q.busy && (loc_idx == s_q.t_idx || loc_act == ACT_HOST));
        accept = loc_valid && loc_ready;
        ra_idx = complete ? s_q.t_idx : loc_idx;
        wb_en  = dat_hit;
        wa_en  = accept && (loc_act == ACT_STORE_HIT
                            || (loc_act == ACT_HOST && loc_cls == RQ_READ0));
    end

    dcc_snoop_unit u_snp (
        .st_i   (snp_st),
        .kind_o (snp_kind)
    );

    dcc_line_store #(
        .NUM_LINES (NUM_LINES),
        .DATA_W    (DATA_W),
        .IDX_W     (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wa_en   (wa_en),
        .wa_idx  (loc_idx),
        .wa_data (loc_wdata),
        .wb_en   (wb_en),
        .wb_idx  (h2d_dat_idx),
        .wb_data (h2d_dat),
        .ra_idx  (ra_idx),
        .ra_data (ra_data),
        .rb_idx  (h2d_snp_idx),
        .rb_data (rb_data)
    );

    always_comb begin
        s_d        = s_q;
        s_d.req_v  = 1'b0;
        s_d.rsp_v  = 1'b0;
        s_d.dat_v  = 1'b0;
        s_d.done_v = 1'b0;

        if (go_hit) begin
            s_d.st[s_q.t_idx] = go_final;
            s_d.t_go          = 1'b1;
        end
        if (dat_hit) s_d.t_dat = 1'b1;

        if (complete) begin
            s_d.busy     = 1'b0;
            s_d.done_v   = 1'b1;
            s_d.done_idx = s_q.t_idx;
            s_d.rdata    = dat_hit ? h2d_dat : ra_data;
        end

        if (h2d_snp_valid) begin
            s_d.st[h2d_snp_idx] = ST_I;
            s_d.rsp_v           = 1'b1;
            s_d.rsp_kind        = snp_kind;
            s_d.rsp_idx         = h2d_snp_idx;
            if (snp_kind == SR_DIRTY) begin
                s_d.dat_v   = 1'b1;
                s_d.dat_idx = h2d_snp_idx;
                s_d.dat     = rb_data;
            end
        end

        if (accept) begin
            case (loc_act)
                ACT_LOAD_HIT, ACT_STORE_HIT, ACT_DROP: begin
                    s_d.done_v   = 1'b1;
                    s_d.done_idx = loc_idx;
                    s_d.rdata    = ra_data;
                    if (loc_act == ACT_STORE_HIT) s_d.st[loc_idx] = ST_M;
                    if (loc_act == ACT_DROP)      s_d.st[loc_idx] = ST_I;
                end
                default: begin
                    s_d.busy    = 1'b1;
                    s_d.t_idx   = loc_idx;
                    s_d.t_cls   = loc_cls;
                    s_d.t_op    = lop_e'(loc_op);
                    s_d.t_go    = 1'b0;
                    s_d.t_dat   = 1'b0;
                    s_d.req_v   = 1'b1;
                    s_d.req_cls = loc_cls;
                    s_d.req_idx = loc_idx;
                    if (loc_cls == RQ_WRITE || loc_cls == RQ_READ0_WR) begin
                        s_d.dat_v   = 1'b1;
                        s_d.dat_idx = loc_idx;
                        s_d.dat     = (loc_cls == RQ_WRITE) ? ra_data : loc_wdata;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign loc_done      = s_q.done_v;
    assign loc_done_idx  = s_q.done_idx;
    assign loc_rdata     = s_q.rdata;
    assign d2h_req_valid = s_q.req_v;
    assign d2h_req_cls   = s_q.req_cls;
    assign d2h_req_idx   = s_q.req_idx;
    assign d2h_rsp_valid = s_q.rsp_v;
    assign d2h_rsp_kind  = s_q.rsp_kind;
    assign d2h_rsp_idx   = s_q.rsp_idx;
    assign d2h_dat_valid = s_q.dat_v;
    assign d2h_dat_idx   = s_q.dat_idx;
    assign d2h_dat       = s_q.dat;

    assert_req_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        d2h_req_valid |=> !d2h_req_valid);

    assert_snoop_reply_R8: assert property (@(posedge clk) disable iff (!rst_n)
        h2d_snp_valid |=> d2h_rsp_valid && d2h_rsp_idx == $past(h2d_snp_idx));

    assert_snoop_inval_R8: assert property (@(posedge clk) disable iff (!rst_n)
        h2d_snp_valid |=> s_q.st[$past(h2d_snp_idx)] == ST_I);

    assert_dirty_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (d2h_rsp_valid && d2h_rsp_kind == SR_DIRTY) |-> d2h_dat_valid && d2h_dat_idx == d2h_rsp_idx);

    assert_write_payload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (d2h_req_valid && (d2h_req_cls == RQ_WRITE || d2h_req_cls == RQ_READ0_WR))
        |-> d2h_dat_valid && d2h_dat_idx == d2h_req_idx);

    assert_hit_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid && loc_ready && loc_op == OP_LOAD && loc_st != ST_I)
        |=> loc_done && !d2h_req_valid);
endmodule

// File: tb/sim_dev_coh_agent.sv
`timescale 1ns/1ps
module sim_dev_coh_agent;
    localparam int NL = 4;
    localparam int DW = 512;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          loc_valid = 0;
    logic [1:0]    loc_op = 0;
    logic [IW-1:0] loc_idx = 0;
    logic [DW-1:0] loc_wdata = '0;
    logic          loc_ready, loc_done;
    logic [IW-1:0] loc_done_idx;
    logic [DW-1:0] loc_rdata;
    logic          d2h_req_valid;
    logic [1:0]    d2h_req_cls;
    logic [IW-1:0] d2h_req_idx;
    logic          d2h_rsp_valid;
    logic [1:0]    d2h_rsp_kind;
    logic [IW-1:0] d2h_rsp_idx;
    logic          d2h_dat_valid;
    logic [IW-1:0] d2h_dat_idx;
    logic [DW-1:0] d2h_dat;
    logic          h2d_rsp_valid = 0;
    logic [IW-1:0] h2d_rsp_idx = 0;
    logic [1:0]    h2d_rsp_state = 0;
    logic          h2d_dat_valid = 0;
    logic [IW-1:0] h2d_dat_idx = 0;
    logic [DW-1:0] h2d_dat = '0;
    logic          h2d_snp_valid = 0;
    logic [IW-1:0] h2d_snp_idx = 0;

    dev_coh_agent #(.NUM_LINES(NL), .LINE_BYTES(DW/8)) u0 (.*);

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    logic [1:0]    ref_st  [NL];
    logic [DW-1:0] ref_dat [NL];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what,
                          input logic [DW-1:0] act, input logic [DW-1:0] exp);
        chk(act == exp, req, what, act, exp);
    endtask

    function automatic logic [DW-1:0] rand_line();
        logic [DW-1:0] v;
        for (int i = 0; i < DW/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // {action, class}: action 0 load hit, 1 store hit, 2 local drop, 3 host request
    function automatic logic [3:0] exp_plan(input logic [1:0] st, input logic [1:0] op);
        case (op)
            2'd0: return (st == 2'd0) ? 4'b11_00 : 4'b00_00;
            2'd1: return (st >= 2'd2) ? 4'b01_00 : 4'b11_01;
            2'd2: return (st == 2'd3) ? 4'b11_11 : 4'b10_00;
            default: begin
                if (st == 2'd0) return 4'b11_10;
                if (st == 2'd1) return 4'b11_01;
                return 4'b01_00;
            end
        endcase
    endfunction

    function automatic logic [1:0] exp_kind(input logic [1:0] st);
        if (st == 2'd3) return 2'd2;
        if (st == 2'd0) return 2'd0;
        return 2'd1;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic snoop(input logic [IW-1:0] idx);
        logic [1:0] ek;
        ek = exp_kind(ref_st[idx]);
        h2d_snp_valid = 1; h2d_snp_idx = idx;
        loc_valid = 1; loc_op = 2'd2; loc_idx = idx + 1'b1;
        #1;
        chk_eq("R11", "ready during snoop", DW'(loc_ready), DW'(0));
        loc_valid = 0;
        tick();
        h2d_snp_valid = 0;
        chk_eq("R8", "snoop answer valid", DW'(d2h_rsp_valid), DW'(1));
        chk_eq("R8", "snoop answer idx", DW'(d2h_rsp_idx), DW'(idx));
        chk_eq("R8", "snoop kind", DW'(d2h_rsp_kind), DW'(ek));
        chk_eq("R8", "dirty data valid", DW'(d2h_dat_valid), DW'(ek == 2'd2));
        if (ek == 2'd2) chk_eq("R8", "dirty data", d2h_dat, ref_dat[idx]);
        ref_st[idx] = 2'd0;
    endtask

    // ord: 0 GO first, 1 data first, 2 together; sg puts a snoop beside the GO
    task automatic local_op(input logic [1:0] op, input logic [IW-1:0] idx,
                            input logic [DW-1:0] wd, input logic [1:0] gs,
                            input int ord, input bit sg);
        logic [3:0]    pl;
        logic [1:0]    cls, post;
        logic [DW-1:0] hd;
        bit            go_done, dat_done;
        string         rq;
        pl = exp_plan(ref_st[idx], op);
        cls = pl[1:0];
        loc_valid = 1; loc_op = op; loc_idx = idx; loc_wdata = wd;
        #1;
        chk_eq("R10", "ready when idle", DW'(loc_ready), DW'(1));
        tick();
        loc_valid = 0;
        if (pl[3:2] != 2'd3) begin
            rq = (pl[3:2] == 2'd0) ? "R2" : (pl[3:2] == 2'd1) ? "R4" : "R7";
            chk_eq(rq, "local done", DW'(loc_done), DW'(1));
            chk_eq(rq, "done idx", DW'(loc_done_idx), DW'(idx));
            chk_eq(rq, "no host request", DW'(d2h_req_valid), DW'(0));
            if (op == 2'd0) chk_eq("R2", "hit data", loc_rdata, ref_dat[idx]);
            if (pl[3:2] == 2'd1) begin ref_st[idx] = 2'd3; ref_dat[idx] = wd; end
            if (pl[3:2] == 2'd2) ref_st[idx] = 2'd0;
            return;
        end
        rq = (cls == 2'd0) ? "R3" : (cls == 2'd1) ? "R5" : (cls == 2'd2) ? "R6" : "R7";
        chk_eq(rq, "request valid", DW'(d2h_req_valid), DW'(1));
        chk_eq(rq, "request class", DW'(d2h_req_cls), DW'(cls));
        chk_eq(rq, "request idx", DW'(d2h_req_idx), DW'(idx));
        chk_eq(rq, "no early done", DW'(loc_done), DW'(0));
        if (cls == 2'd3) begin
            chk_eq("R7", "write payload valid", DW'(d2h_dat_valid), DW'(1));
            chk_eq("R7", "write payload", d2h_dat, ref_dat[idx]);
        end
        if (cls == 2'd2) begin
            chk_eq("R6", "push payload valid", DW'(d2h_dat_valid), DW'(1));
            chk_eq("R6", "push payload", d2h_dat, wd);
        end
        loc_valid = 1; loc_op = 2'd0; loc_idx = idx;
        #1;
        chk_eq("R10", "pending line refused", DW'(loc_ready), DW'(0));
        loc_valid = 0;
        hd = rand_line();
        go_done = 0; dat_done = (cls != 2'd0);
        if (cls == 2'd0 && ord == 1) begin
            h2d_dat_valid = 1; h2d_dat_idx = idx; h2d_dat = hd;
            tick();
            h2d_dat_valid = 0; dat_done = 1;
            chk_eq("R3", "waits for GO", DW'(loc_done), DW'(0));
        end
        if (cls == 2'd0 && ord == 0 && !sg) begin
            h2d_rsp_valid = 1; h2d_rsp_idx = idx; h2d_rsp_state = gs;
            tick();
            h2d_rsp_valid = 0; go_done = 1;
            chk_eq("R3", "waits for data", DW'(loc_done), DW'(0));
        end
        if (!go_done) begin
            h2d_rsp_valid = 1; h2d_rsp_idx = idx;
            h2d_rsp_state = (cls == 2'd0) ? gs : (cls == 2'd1) ? 2'd2 : 2'd0;
        end
        if (!dat_done) begin
            h2d_dat_valid = 1; h2d_dat_idx = idx; h2d_dat = hd;
        end
        if (sg) begin h2d_snp_valid = 1; h2d_snp_idx = idx; end
        tick();
        h2d_rsp_valid = 0; h2d_dat_valid = 0; h2d_snp_valid = 0;
        chk_eq(rq, "completion", DW'(loc_done), DW'(1));
        chk_eq(rq, "completion idx", DW'(loc_done_idx), DW'(idx));
        if (cls == 2'd0) chk_eq("R3", "miss data", loc_rdata, hd);
        post = (cls == 2'd0) ? gs : (cls == 2'd1) ? 2'd3 : 2'd0;
        ref_st[idx] = post;
        if (cls == 2'd0) ref_dat[idx] = hd;
        if (cls == 2'd1) ref_dat[idx] = wd;
        if (sg) begin
            chk_eq("R9", "snoop beside GO", DW'(d2h_rsp_valid), DW'(1));
            chk_eq("R9", "kind after GO", DW'(d2h_rsp_kind), DW'(exp_kind(post)));
            if (post == 2'd3) chk_eq("R9", "dirty after GO", d2h_dat, wd);
            ref_st[idx] = 2'd0;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NL; i++) begin ref_st[i] = 2'd0; ref_dat[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        chk_eq("R1", "ready after reset", DW'(loc_ready), DW'(1));
        chk_eq("R1", "no request", DW'(d2h_req_valid), DW'(0));
        chk_eq("R1", "no answer", DW'(d2h_rsp_valid), DW'(0));
        chk_eq("R1", "no data", DW'(d2h_dat_valid), DW'(0));
        chk_eq("R1", "no done", DW'(loc_done), DW'(0));
        @(negedge clk);
        for (int i = 0; i < NL; i++) snoop(IW'(i));       // R1: all miss

        local_op(2'd0, 0, '0, 2'd2, 1, 0);               // R3 data first, grant E
        local_op(2'd0, 0, '0, 2'd0, 0, 0);               // R2 hit
        local_op(2'd1, 0, rand_line(), 2'd0, 0, 0);      // R4 store in E
        snoop(0);                                        // R8 dirty
        local_op(2'd0, 1, '0, 2'd1, 0, 0);               // R3 GO first, grant S
        local_op(2'd1, 1, rand_line(), 2'd0, 0, 0);      // R5 store in S
        local_op(2'd0, 1, '0, 2'd0, 0, 0);               // R2 returns store data
        local_op(2'd2, 1, '0, 2'd0, 0, 0);               // R7 write back
        snoop(1);
        local_op(2'd0, 2, '0, 2'd1, 2, 0);               // R3 together
        local_op(2'd2, 2, '0, 2'd0, 0, 0);               // R7 silent drop
        snoop(2);
        local_op(2'd3, 3, rand_line(), 2'd0, 0, 0);      // R6 push from I
        snoop(3);
        local_op(2'd0, 3, '0, 2'd2, 1, 1);               // R9 GO(E)+snoop -> clean
        local_op(2'd1, 3, rand_line(), 2'd0, 0, 1);      // R9 Read0 GO+snoop -> dirty

        for (int n = 0; n < 400; n++) begin
            if ($urandom % 6 == 0) snoop(IW'($urandom % NL));
            else local_op(2'($urandom % 4), IW'($urandom % NL), rand_line(),
                          ($urandom % 2 == 0) ? 2'd1 : 2'd2,
                          int'($urandom % 3), ($urandom % 8) == 0);
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule